// File: doc/BRIEF.md
# Row-Parallel Matrix Dot-Product Engine

This block computes one 32-bit scalar: the sum of the element-wise products of two square matrices of signed 32-bit integers. Each matrix sits in its own on-chip memory. Software or a neighbouring block fills both memories through one write port per memory. It then pulses `start`. The engine walks the matrices one row at a time and later reports the result on `sum` together with a one-cycle `done` pulse.

Each memory can serve only two reads per clock. A full row of 25 elements therefore takes 13 read slots, and a new row begins every 13 cycles. In the final slot of each row only one element is left, and the second port stays idle. The engine gathers the row's operands into registers. Once the last pair lands, it forms all 25 products at the same time, reduces them through a binary adder tree into a partial sum, and adds that partial sum into a wrapping accumulator. Gathering of the next row overlaps the multiply and accumulate of the current row.

Control is a four-state machine:
- **IDLE**: waits for `start`. An accepted start clears the accumulator and moves to FETCH.
- **FETCH**: issues reads. It moves to DRAIN after the read slot for the last row's last element.
- **DRAIN**: waits until the last row's partial sum has been accumulated, then moves to DONE.
- **DONE**: raises `done` for one cycle and returns to IDLE.

Top module: `mac_row_engine`

## Requirements
- R1: Each matrix is held as 625 words. Element (row i, column j) is at word address i*25+j. A write with the enable high in one cycle is visible to every read issued in a later cycle.
- R2: The final result is the sum over all i and j of A[i][j]*B[i][j], starting from zero. Products and sums are taken modulo 2^32 on signed 32-bit two's-complement values.
- R3: Each memory sees at most two reads per cycle. In read slot k of a row, the first port reads column 2k and the second port reads column 2k+1.
- R4: Rows are spaced 13 cycles apart. Take cycle 0 as the cycle in which a start is sampled. Then `sum` reads 0 in cycles 1 through 16, and the partial sum of row r has been added to `sum` from cycle 17+13r onward.
- R5: In the 13th read slot of each row only column 24 is read. The second read port issues no read in that slot.
- R6: The 25 products of a row are formed in parallel and reduced by an adder tree into one partial sum per row.
- R7: `done` is high for exactly one cycle, in cycle 329 (25*13+4) after the start cycle. DONE is always entered from DRAIN.
- R8: After an accepted start, `sum` reads 0 in the next cycle. Once `done` has pulsed, `sum` holds the final value until the next accepted start.
- R9: A start pulse that arrives in FETCH, DRAIN or DONE is ignored. It neither restarts the walk, moves `done`, nor changes `sum`.
- R10: After reset, `done` is 0 and `sum` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only in IDLE |
| a_wr_en | input | 1 | Write enable for matrix A memory |
| a_wr_addr | input | 10 | Word address for matrix A (i*25+j) |
| a_wr_data | input | 32 | Signed element written to matrix A |
| b_wr_en | input | 1 | Write enable for matrix B memory |
| b_wr_addr | input | 10 | Word address for matrix B (i*25+j) |
| b_wr_data | input | 32 | Signed element written to matrix B |
| done | output | 1 | One-cycle completion pulse |
| sum | output | 32 | Accumulated dot product |

## Verification
Every result is tied to a fixed cycle count after the cycle in which `start` is sampled:
- `sum` must be cleared one cycle later.
- The first row's partial sum appears at cycle 17, and each later row follows 13 cycles after the previous one.
- `done` rises at cycle 329, together with the final `sum`.

The bench counts clock cycles from the start pulse and samples each output at the falling edge of exactly the cycle in which it is due. It also checks the cycle just before the first row's partial sum, where `sum` must still read 0. Start pulses injected early in FETCH, late in FETCH and during the DONE cycle must leave every one of these cycle positions and values unchanged.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Controller states of the row engine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } eng_state_t;

    // Read slots needed for n elements through two ports
    function automatic int pair_slots(input int n);
        return (n + 1) / 2;
    endfunction

endpackage

// File: rtl/mac_dpmem.sv
module mac_dpmem #(
    parameter int DW    = 32,
    parameter int DEPTH = 625,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en0,
    input  logic [AW-1:0] rd_addr0,
    input  logic          rd_en1,
    input  logic [AW-1:0] rd_addr1,
    output logic [DW-1:0] rd_data0,
    output logic [DW-1:0] rd_data1
);

    logic [DW-1:0] store [DEPTH];

    // One write port, two registered read ports
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
        if (rd_en0) begin
            rd_data0 <= store[rd_addr0];
        end
        if (rd_en1) begin
            rd_data1 <= store[rd_addr1];
        end
    end

endmodule

// File: rtl/mac_fetch_sched.sv
module mac_fetch_sched #(
    parameter int DIM = 25,
    parameter int AW  = 10,
    parameter int SW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic          issue,
    output logic [SW-1:0] slot,
    output logic          last,
    output logic [AW-1:0] rd_addr0,
    output logic [AW-1:0] rd_addr1,
    output logic          rd_en1
);

    localparam int SLOTS = mac_pkg::pair_slots(DIM);
    localparam int RW    = (DIM > 1) ? $clog2(DIM) : 1;

    logic          active_q;
    logic [SW-1:0] slot_q;
    logic [RW-1:0] row_q;
    logic          slot_end;
    logic          row_end;

    assign slot_end = (slot_q == SW'(SLOTS - 1));
    assign row_end  = (row_q == RW'(DIM - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            slot_q   <= '0;
            row_q    <= '0;
        end else if (go) begin
            active_q <= 1'b1;
            slot_q   <= '0;
            row_q    <= '0;
        end else if (active_q) begin
            if (slot_end) begin
                slot_q <= '0;
                if (row_end) begin
                    active_q <= 1'b0;
                end else begin
                    row_q <= row_q + 1'b1;
                end
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    always_comb begin
        issue    = active_q;
        slot     = slot_q;
        last     = active_q && slot_end && row_end;
        rd_addr0 = AW'(int'(row_q) * DIM + 2 * int'(slot_q));
        rd_addr1 = AW'(int'(row_q) * DIM + 2 * int'(slot_q) + 1);
        rd_en1   = active_q && ((2 * int'(slot_q) + 1) < DIM);
    end

    AST_ROW_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && slot_q == '0 && row_q != '0) |-> ($past(issue) && $past(slot_q) == SW'(SLOTS - 1))); // R4
    AST_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (2 * int'(slot_q) + 1) >= DIM) |-> !rd_en1); // R5
    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && rd_en1) |-> (rd_addr1 == rd_addr0 + 1'b1)); // R3

endmodule

// File: rtl/mac_row_dot.sv
module mac_row_dot #(
    parameter int DIM = 25,
    parameter int DW  = 32
) (
    input  logic [DW-1:0] opa [DIM],
    input  logic [DW-1:0] opb [DIM],
    output logic [DW-1:0] dot
);

    localparam int LV     = (DIM > 1) ? $clog2(DIM) : 1;
    localparam int LEAVES = 1 << LV;

    // Level 0 holds the products, each level above halves the count
    for (genvar l = 0; l <= LV; l++) begin : g_lvl
        logic [DW-1:0] s [LEAVES >> l];
        for (genvar k = 0; k < (LEAVES >> l); k++) begin : g_n
            if (l == 0) begin : g_leaf
                if (k < DIM) begin : g_mul
                    assign s[k] = opa[k] * opb[k];
                end else begin : g_pad
                    assign s[k] = '0;
                end
            end else begin : g_add
                assign s[k] = g_lvl[l-1].s[2*k] + g_lvl[l-1].s[2*k+1];
            end
        end
    end

    assign dot = g_lvl[LV].s[0];

endmodule

// File: rtl/mac_row_engine.sv
module mac_row_engine #(
    parameter int DIM = 25,
    parameter int DW  = 32,
    parameter int AW  = $clog2(DIM * DIM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          a_wr_en,
    input  logic [AW-1:0] a_wr_addr,
    input  logic [DW-1:0] a_wr_data,
    input  logic          b_wr_en,
    input  logic [AW-1:0] b_wr_addr,
    input  logic [DW-1:0] b_wr_data,
    output logic          done,
    output logic [DW-1:0] sum
);

    import mac_pkg::*;

    localparam int DEPTH = DIM * DIM;
    localparam int SLOTS = pair_slots(DIM);
    localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    eng_state_t state_q, state_d;
    logic          go;
    logic          issue, last, rd_en1;
    logic [SW-1:0] slot;
    logic [AW-1:0] rd_addr0, rd_addr1;
    logic [DW-1:0] a_rd0, a_rd1, b_rd0, b_rd1;
    logic          cap_valid, cap_last;
    logic [SW-1:0] cap_slot;
    logic          row_valid, row_last;
    logic          psum_valid, psum_last;
    logic [DW-1:0] psum_q, acc_q, row_dot;
    logic [DW-1:0] gath_a [DIM];
    logic [DW-1:0] gath_b [DIM];

    assign go = (state_q == ST_IDLE) && start;

    mac_fetch_sched #(.DIM(DIM), .AW(AW), .SW(SW)) i_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .issue    (issue),
        .slot     (slot),
        .last     (last),
        .rd_addr0 (rd_addr0),
        .rd_addr1 (rd_addr1),
        .rd_en1   (rd_en1)
    );

    mac_dpmem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) i_mem_a (
        .clk      (clk),
        .wr_en    (a_wr_en),
        .wr_addr  (a_wr_addr),
        .wr_data  (a_wr_data),
        .rd_en0   (issue),
        .rd_addr0 (rd_addr0),
        .rd_en1   (rd_en1),
        .rd_addr1 (rd_addr1),
        .rd_data0 (a_rd0),
        .rd_data1 (a_rd1)
    );

    mac_dpmem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) i_mem_b (
        .clk      (clk),
        .wr_en    (b_wr_en),
        .wr_addr  (b_wr_addr),
        .wr_data  (b_wr_data),
        .rd_en0   (issue),
        .rd_addr0 (rd_addr0),
        .rd_en1   (rd_en1),
        .rd_addr1 (rd_addr1),
        .rd_data0 (b_rd0),
        .rd_data1 (b_rd1)
    );

    // Track which slot the returning read data belongs to
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_last  <= 1'b0;
            cap_slot  <= '0;
        end else begin
            cap_valid <= issue;
            cap_last  <= last;
            cap_slot  <= slot;
        end
    end

    // Operand gather registers, one pair per column
    for (genvar c = 0; c < DIM; c++) begin : g_gath
        always_ff @(posedge clk) begin
            if (cap_valid) begin
                if (c == 2 * int'(cap_slot)) begin
                    gath_a[c] <= a_rd0;
                    gath_b[c] <= b_rd0;
                end else if (c == 2 * int'(cap_slot) + 1) begin
                    gath_a[c] <= a_rd1;
                    gath_b[c] <= b_rd1;
                end
            end
        end
    end

    mac_row_dot #(.DIM(DIM), .DW(DW)) i_dot (
        .opa (gath_a),
        .opb (gath_b),
        .dot (row_dot)
    );

    // Row complete -> partial sum register -> accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_valid  <= 1'b0;
            row_last   <= 1'b0;
            psum_valid <= 1'b0;
            psum_last  <= 1'b0;
            psum_q     <= '0;
            acc_q      <= '0;
        end else begin
            row_valid  <= cap_valid && (cap_slot == SW'(SLOTS - 1));
            row_last   <= cap_last;
            psum_valid <= row_valid;
            psum_last  <= row_last;
            if (row_valid) begin
                psum_q <= row_dot;
            end
            if (go) begin
                acc_q <= '0;
            end else if (psum_valid) begin
                acc_q <= acc_q + psum_q;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_FETCH;
            ST_FETCH: if (last)      state_d = ST_DRAIN;
            ST_DRAIN: if (psum_last) state_d = ST_DONE;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        done = (state_q == ST_DONE);
        sum  = acc_q;
    end

    AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_en || b_wr_en) |-> ((!a_wr_en || a_wr_addr < AW'(DEPTH)) && (!b_wr_en || b_wr_addr < AW'(DEPTH)))); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_FROM_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> ($past(state_q) == ST_DRAIN)); // R7
    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> $stable(sum)); // R8
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start && !psum_valid) |=> $stable(acc_q)); // R9
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (sum == '0 && state_q == ST_FETCH)); // R8

endmodule

// File: tb/test_mac_row_engine.sv
`timescale 1ns/1ps
module test_mac_row_engine;

    localparam int DIM   = 25;
    localparam int DW    = 32;
    localparam int AW    = 10;
    localparam int SLOTS = 13;
    localparam int LAT   = DIM * SLOTS + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          a_wr_en = 1'b0, b_wr_en = 1'b0;
    logic [AW-1:0] a_wr_addr = '0, b_wr_addr = '0;
    logic [DW-1:0] a_wr_data = '0, b_wr_data = '0;
    logic          done;
    logic [DW-1:0] sum;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mac_row_engine #(.DIM(DIM), .DW(DW), .AW(AW)) i_mac_row_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .a_wr_en   (a_wr_en),
        .a_wr_addr (a_wr_addr),
        .a_wr_data (a_wr_data),
        .b_wr_en   (b_wr_en),
        .b_wr_addr (b_wr_addr),
        .b_wr_data (b_wr_data),
        .done      (done),
        .sum       (sum)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    function automatic int mix(input int p, input int i, input int j);
        int x;
        x = (p * 977 + i * 131 + j * 7919) * 1103515245 + 12345;
        return x ^ (x >>> 13);
    endfunction

    function automatic int val_a(input int p, input int i, input int j);
        case (p)
            0: return i * DIM + j;
            1: return i - j;
            2: return 32'h7fff0000 + i * DIM + j;
            3: return mix(p, i, j);
            default: return -1;
        endcase
    endfunction

    function automatic int val_b(input int p, input int i, input int j);
        case (p)
            0: return 1;
            1: return i + 2 * j - 7;
            2: return 40000 + j;
            3: return mix(p + 1, i, j);
            default: return -1;
        endcase
    endfunction

    function automatic int row_sum(input int p, input int i);
        int s = 0;
        for (int j = 0; j < DIM; j++) s += val_a(p, i, j) * val_b(p, i, j);
        return s;
    endfunction

    // R1: load both memories at address i*25+j
    task automatic load(input int p);
        for (int i = 0; i < DIM; i++) begin
            for (int j = 0; j < DIM; j++) begin
                @(negedge clk);
                a_wr_en   = 1'b1;
                b_wr_en   = 1'b1;
                a_wr_addr = AW'(i * DIM + j);
                b_wr_addr = AW'(i * DIM + j);
                a_wr_data = val_a(p, i, j);
                b_wr_data = val_b(p, i, j);
            end
        end
        @(negedge clk);
        a_wr_en = 1'b0;
        b_wr_en = 1'b0;
    endtask

    task automatic run_job(input int p, input int extra_start);
        int total = 0;
        int r0, r1;
        int first_done = 0;
        int ndone = 0;
        for (int i = 0; i < DIM; i++) total += row_sum(p, i);
        r0 = row_sum(p, 0);
        r1 = row_sum(p, 1);
        load(p);
        @(negedge clk);
        start = 1'b1;                       // cycle 0
        for (int n = 1; n <= LAT + 60; n++) begin
            @(negedge clk);
            start = (extra_start == n);     // R9: pulse while busy or in DONE
            if (n == 1)  check("R8 sum cleared after start", sum, 32'd0);
            if (n == 16) check("R4 sum before first row", sum, 32'd0);
            if (n == 17) check("R4 R6 first row partial", sum, r0);
            if (n == 29) check("R4 first row only", sum, r0);
            if (n == 30) check("R4 second row partial", sum, r0 + r1);
            if (n == LAT) check("R2 R3 R5 R6 final sum at done", sum, total);
            if (done) begin
                ndone++;
                if (first_done == 0) first_done = n;
            end
        end
        start = 1'b0;
        check("R7 R9 done cycle", first_done, LAT);
        check("R7 R9 single done pulse", ndone, 1);
        check("R8 R9 sum held after done", sum, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 done after reset", {31'd0, done}, 32'd0);
        check("R10 sum after reset", sum, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 done idle", {31'd0, done}, 32'd0);
        run_job(0, 0);
        run_job(1, 150);
        run_job(2, LAT);
        run_job(3, 5);
        run_job(4, 300);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule